// File: doc/BRIEF.md
# IPv4 Header Forwarding Processor

This block sits in a 32-bit word stream of IPv4 frames and prepares each frame for forwarding. Each frame is marked by a data-enable, a start-of-frame flag on its first word (the first IPv4 header word) and an end-of-frame flag on its last payload word. Two trailer words follow, with data-enable still high. While a frame streams through, the block parses the header. It checks the version and header length, sums the header in one's-complement arithmetic and captures the time-to-live. It reaches a verdict when the last header word arrives.

Every word is held in a delay line long enough to cover the longest header, so the verdict is known before the frame's first word leaves the block. Valid frames leave with the time-to-live lowered by one and the checksum patched to match, and a marker shows the first payload word. A frame whose time-to-live has run out is not forwarded; a one-cycle pulse asks a neighbouring block to build the error message. A mode pin chooses what happens to malformed frames: they are either discarded whole, or passed through untouched with an error pulse.

Top module: `ipv4_hdr_fwd`

## Requirements
- R1: Every output signal follows its input by exactly 16 clock cycles: the frame markers move in step with the data, gaps in data-enable are kept, and `out_data` is zero whenever `out_den` is low.
- R2: A header is malformed when the version nibble (word 0 bits 31:28) is not 4, or when the header-length nibble (word 0 bits 27:24, counted in 32-bit words) is below 5.
- R3: A header is malformed unless the 16-bit one's-complement sum of both halves of all its header words, checksum included, equals 0xFFFF.
- R4: `out_hdr_err` pulses together with the output slot of a malformed frame's first word. When `drop_mode` is 1, the whole frame, trailers included, is removed from the output. When it is 0, the frame leaves unchanged.
- R5: In a forwarded valid frame, the time-to-live byte (word 2 bits 31:24) leaves reduced by one, and the other bytes of the frame are unchanged except for the checksum.
- R6: In a forwarded valid frame, the checksum (word 2 bits 15:0) leaves as the incoming value plus 0x0100, with any carry out of bit 15 added back into bit 0.
- R7: A valid frame that arrives with time-to-live 0 or 1 is removed from the output in both modes, and `icmp_req` pulses for one cycle in the output slot of its first word.
- R8: `out_sop` pulses on the output word whose index equals the header length (the first word is index 0, and only words with data-enable high are counted). It pulses only for forwarded valid frames, and only when that word lies at or before the end-of-frame word.
- R9: A frame whose end-of-frame word arrives before its last header word is malformed.
- R10: Frames may follow each other with no idle cycle between them, and short frames may pile up in the delay line, without any verdict being lost or reordered.
- R11: `drop_mode` is sampled when the frame's first word reaches the output stage; it must be held steady while a frame is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Incoming word |
| in_den | input | 1 | Incoming word is valid (header, payload or trailer) |
| in_sof | input | 1 | Incoming word is the first header word |
| in_eof | input | 1 | Incoming word is the last payload word |
| drop_mode | input | 1 | 1: discard malformed frames; 0: pass them with an error pulse |
| out_data | output | 32 | Outgoing word, edited where required |
| out_den | output | 1 | Outgoing word is valid |
| out_sof | output | 1 | Outgoing first header word |
| out_eof | output | 1 | Outgoing last payload word |
| out_sop | output | 1 | Outgoing first payload word |
| out_hdr_err | output | 1 | Malformed-frame pulse, in the first-word slot |
| icmp_req | output | 1 | Time-exceeded request pulse, in the first-word slot |

## Verification
The hardest state to reach is a verdict queue that holds several entries at once. It only fills when frames of only a few words arrive back to back, so that several first words sit in the 16-stage delay line together. The stimulus therefore sends runs of frames cut short after one word, mixed with full-length frames and with no idle cycle between them. The end-around carry of the checksum patch is the other rare case. The bench reaches it by stepping the identification field until the computed checksum has a high byte of 0xFF.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;

    localparam int WORD_W = 32;
    localparam int IHL_W  = 4;
    localparam int MAX_IHL = (1 << IHL_W) - 1;

    localparam logic [IHL_W-1:0] MIN_IHL  = IHL_W'(5);
    localparam logic [IHL_W-1:0] TTL_WORD = IHL_W'(2);
    localparam logic [3:0]       IP_VER   = 4'd4;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              den;
        logic              sof;
        logic              eof;
    } beat_t;

    typedef struct packed {
        logic             hdr_ok;
        logic             ttl_exp;
        logic [IHL_W-1:0] ihl;
    } verdict_t;

    typedef enum logic {
        P_IDLE,
        P_HDR
    } parse_st_t;

    // one's-complement 16-bit addition with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction

    function automatic logic [15:0] oc_word_add(input logic [15:0] acc,
                                                input logic [WORD_W-1:0] w);
        return oc_add(oc_add(acc, w[31:16]), w[15:0]);
    endfunction

    // checksum patch for a time-to-live lowered by one
    function automatic logic [15:0] csum_ttl_step(input logic [15:0] c);
        return oc_add(c, 16'h0100);
    endfunction

endpackage

// File: rtl/ipv4_hdr_parser.sv
module ipv4_hdr_parser
    import ipv4_hdr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  beat_t    in_b,
    output logic     push,
    output verdict_t push_v
);

    parse_st_t        st;
    logic [IHL_W-1:0] widx;
    logic [IHL_W-1:0] hlen;
    logic             ver_ok;
    logic             len_ok;
    logic [7:0]       ttl;
    logic [15:0]      acc;

    logic [IHL_W-1:0] ihl_in;
    logic [IHL_W-1:0] hlen_in;
    logic [15:0]      acc_first;
    logic [15:0]      acc_next;
    logic             hdr_last;

    always_comb begin
        ihl_in    = in_b.data[27:24];
        hlen_in   = (ihl_in < MIN_IHL) ? MIN_IHL : ihl_in;
        acc_first = oc_word_add(16'h0000, in_b.data);
        acc_next  = oc_word_add(acc, in_b.data);
        hdr_last  = (st == P_HDR) && (widx == hlen - IHL_W'(1));

        push   = 1'b0;
        push_v = '{hdr_ok: 1'b0, ttl_exp: 1'b0, ihl: hlen_in};

        if (in_b.den && in_b.sof) begin
            // a frame of one word cannot hold a header
            if (in_b.eof) begin
                push = 1'b1;
            end
        end else if (in_b.den && (st == P_HDR)) begin
            if (hdr_last) begin
                push           = 1'b1;
                push_v.hdr_ok  = ver_ok && len_ok && (acc_next == 16'hFFFF);
                push_v.ttl_exp = (ttl <= 8'd1);
                push_v.ihl     = hlen;
            end else if (in_b.eof) begin
                push       = 1'b1;
                push_v.ihl = hlen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= P_IDLE;
            widx   <= '0;
            hlen   <= MIN_IHL;
            ver_ok <= 1'b0;
            len_ok <= 1'b0;
            ttl    <= '0;
            acc    <= '0;
        end else if (in_b.den) begin
            if (in_b.sof) begin
                st     <= in_b.eof ? P_IDLE : P_HDR;
                widx   <= IHL_W'(1);
                hlen   <= hlen_in;
                ver_ok <= (in_b.data[31:28] == IP_VER);
                len_ok <= (ihl_in >= MIN_IHL);
                acc    <= acc_first;
            end else if (st == P_HDR) begin
                acc  <= acc_next;
                widx <= widx + IHL_W'(1);
                if (widx == TTL_WORD) begin
                    ttl <= in_b.data[31:24];
                end
                if (push) begin
                    st <= P_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/ipv4_verdict_fifo.sv
module ipv4_verdict_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wp[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                wp <= wp + (AW+1)'(1);
            end
            if (pop && !empty) begin
                rp <= rp + (AW+1)'(1);
            end
        end
    end

endmodule

// File: rtl/ipv4_beat_delay.sv
module ipv4_beat_delay
    import ipv4_hdr_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d_in,
    output beat_t d_out
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        beat_t q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[s-1].q;
            end
        end
    end

    assign d_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/ipv4_hdr_editor.sv
module ipv4_hdr_editor
    import ipv4_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drop_mode,
    input  beat_t             b,
    input  verdict_t          vq_rdata,
    input  logic              vq_empty,
    output logic              vq_pop,
    output logic [WORD_W-1:0] out_data,
    output logic              out_den,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_sop,
    output logic              out_hdr_err,
    output logic              icmp_req
);

    localparam int OW = IHL_W + 1;
    localparam logic [OW-1:0] IDX_MAX = '1;

    verdict_t        cur_v;
    logic            fwd;
    logic [OW-1:0]   oidx;
    logic            eof_seen;

    logic            is_sof;
    verdict_t        v_new;
    verdict_t        v_cur;
    logic            fwd_new;
    logic            fwd_cur;
    logic [OW-1:0]   idx_cur;
    logic            ended;
    logic            pass;
    logic            edit;
    logic            sop;
    logic [WORD_W-1:0] word_out;

    always_comb begin
        is_sof  = b.den && b.sof;
        v_new   = vq_empty ? '{hdr_ok: 1'b0, ttl_exp: 1'b0, ihl: MIN_IHL} : vq_rdata;
        vq_pop  = is_sof && !vq_empty;
        v_cur   = is_sof ? v_new : cur_v;
        fwd_new = v_new.hdr_ok ? !v_new.ttl_exp : !drop_mode;
        fwd_cur = is_sof ? fwd_new : fwd;
        idx_cur = is_sof ? '0 : oidx;
        ended   = is_sof ? 1'b0 : eof_seen;
        pass    = b.den && fwd_cur;
        edit    = pass && v_cur.hdr_ok && (idx_cur == {1'b0, TTL_WORD});
        sop     = pass && v_cur.hdr_ok && (idx_cur == {1'b0, v_cur.ihl}) && !ended;
        word_out = edit ? {b.data[31:24] - 8'd1, b.data[23:16], csum_ttl_step(b.data[15:0])}
                        : b.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_v       <= '0;
            fwd         <= 1'b0;
            oidx        <= '0;
            eof_seen    <= 1'b0;
            out_data    <= '0;
            out_den     <= 1'b0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            out_sop     <= 1'b0;
            out_hdr_err <= 1'b0;
            icmp_req    <= 1'b0;
        end else begin
            if (is_sof) begin
                cur_v <= v_new;
                fwd   <= fwd_new;
            end
            if (b.den) begin
                oidx     <= (idx_cur == IDX_MAX) ? idx_cur : idx_cur + OW'(1);
                eof_seen <= ended || b.eof;
            end
            out_data    <= pass ? word_out : '0;
            out_den     <= pass;
            out_sof     <= pass && b.sof;
            out_eof     <= pass && b.eof;
            out_sop     <= sop;
            out_hdr_err <= is_sof && !v_new.hdr_ok;
            icmp_req    <= is_sof && v_new.hdr_ok && v_new.ttl_exp;
        end
    end

endmodule

// File: rtl/ipv4_hdr_fwd.sv
module ipv4_hdr_fwd
    import ipv4_hdr_pkg::*;
#(
    parameter int VQ_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] in_data,
    input  logic        in_den,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        drop_mode,
    output logic [31:0] out_data,
    output logic        out_den,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_sop,
    output logic        out_hdr_err,
    output logic        icmp_req
);

    localparam int STAGES = MAX_IHL;
    localparam int VW     = $bits(verdict_t);

    beat_t          in_b;
    beat_t          dly_b;
    logic           vq_push;
    logic           vq_pop;
    logic           vq_empty;
    logic           vq_full;
    verdict_t       push_v;
    verdict_t       vq_rd;
    logic [VW-1:0]  vq_raw;

    assign in_b  = '{data: in_data, den: in_den, sof: in_sof, eof: in_eof};
    assign vq_rd = verdict_t'(vq_raw);

    ipv4_hdr_parser u_parser (
        .clk    (clk),
        .rst    (rst),
        .in_b   (in_b),
        .push   (vq_push),
        .push_v (push_v)
    );

    ipv4_verdict_fifo #(.DEPTH(VQ_DEPTH), .W(VW)) u_vq (
        .clk   (clk),
        .rst   (rst),
        .push  (vq_push),
        .wdata (push_v),
        .pop   (vq_pop),
        .rdata (vq_raw),
        .empty (vq_empty),
        .full  (vq_full)
    );

    ipv4_beat_delay #(.STAGES(STAGES)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .d_in  (in_b),
        .d_out (dly_b)
    );

    ipv4_hdr_editor u_edit (
        .clk         (clk),
        .rst         (rst),
        .drop_mode   (drop_mode),
        .b           (dly_b),
        .vq_rdata    (vq_rd),
        .vq_empty    (vq_empty),
        .vq_pop      (vq_pop),
        .out_data    (out_data),
        .out_den     (out_den),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .out_sop     (out_sop),
        .out_hdr_err (out_hdr_err),
        .icmp_req    (icmp_req)
    );

endmodule

// File: rtl/ipv4_hdr_fwd_chk.sv
module ipv4_hdr_fwd_chk #(
    parameter int LAT = 16
) (
    input logic clk,
    input logic rst,
    input logic in_den,
    input logic in_sof,
    input logic out_den,
    input logic out_sof,
    input logic out_sop,
    input logic out_hdr_err,
    input logic icmp_req,
    input logic vq_push,
    input logic vq_full
);

    AST_LATENCY_DEN: assert property (@(posedge clk) disable iff (rst)
        out_den |-> $past(in_den, LAT)); // R1

    AST_LATENCY_SOF: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> $past(in_sof, LAT)); // R1

    AST_ERR_AT_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
        out_hdr_err |-> $past(in_sof, LAT)); // R4

    AST_SOP_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> (out_den && !out_sof)); // R8

    AST_ICMP_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        icmp_req |-> (!out_den && !out_hdr_err)); // R7

    AST_ICMP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        icmp_req |=> !icmp_req); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(vq_push && vq_full)); // R10

endmodule

bind ipv4_hdr_fwd ipv4_hdr_fwd_chk #(.LAT(ipv4_hdr_pkg::MAX_IHL + 1)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_den      (in_den),
    .in_sof      (in_sof),
    .out_den     (out_den),
    .out_sof     (out_sof),
    .out_sop     (out_sop),
    .out_hdr_err (out_hdr_err),
    .icmp_req    (icmp_req),
    .vq_push     (vq_push),
    .vq_full     (vq_full)
);

// File: tb/ipv4_hdr_fwd_tb_top.sv
module ipv4_hdr_fwd_tb_top;

    localparam int LAT = 16;

    typedef struct {
        logic [31:0] d;
        logic        den;
        logic        sof;
        logic        eof;
        logic        sop;
        logic        err;
        logic        icmp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_den = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        drop_mode = 1'b1;
    logic [31:0] out_data;
    logic        out_den;
    logic        out_sof;
    logic        out_eof;
    logic        out_sop;
    logic        out_hdr_err;
    logic        icmp_req;

    int          n_cmp = 0;
    int          n_bad = 0;
    exp_t        exp_q[$];
    logic [31:0] pw[$];

    always #10 clk = ~clk;

    ipv4_hdr_fwd dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_den      (in_den),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .drop_mode   (drop_mode),
        .out_data    (out_data),
        .out_den     (out_den),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .out_sop     (out_sop),
        .out_hdr_err (out_hdr_err),
        .icmp_req    (icmp_req)
    );

    function automatic exp_t idle_exp();
        exp_t e;
        e.d = '0; e.den = 0; e.sof = 0; e.eof = 0;
        e.sop = 0; e.err = 0; e.icmp = 0; e.tag = "idle";
        return e;
    endfunction

    task automatic fail(input string req, input string tag,
                        input logic [31:0] act, input logic [31:0] expv);
        n_bad++;
        $display("FAIL %s [%s] t=%0t: actual %h expected %h", req, tag, $time, act, expv);
    endtask

    task automatic check_out(input exp_t e);
        n_cmp++;
        if (out_data !== e.d)      fail("R5/R6 data", e.tag, out_data, e.d);
        if (out_den !== e.den)     fail("R4 den", e.tag, {31'b0, out_den}, {31'b0, e.den});
        if (out_sof !== e.sof)     fail("R1 sof", e.tag, {31'b0, out_sof}, {31'b0, e.sof});
        if (out_eof !== e.eof)     fail("R1 eof", e.tag, {31'b0, out_eof}, {31'b0, e.eof});
        if (out_sop !== e.sop)     fail("R8 sop", e.tag, {31'b0, out_sop}, {31'b0, e.sop});
        if (out_hdr_err !== e.err) fail("R2/R3/R9 err", e.tag, {31'b0, out_hdr_err}, {31'b0, e.err});
        if (icmp_req !== e.icmp)   fail("R7 icmp", e.tag, {31'b0, icmp_req}, {31'b0, e.icmp});
    endtask

    // one cycle: compare the slot due now, then drive and queue its expectation (R1)
    task automatic step(input logic [31:0] d, input logic den, input logic sof,
                        input logic eof, input exp_t e);
        @(negedge clk);
        check_out(exp_q.pop_front());
        in_data = d; in_den = den; in_sof = sof; in_eof = eof;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step('0, 0, 0, 0, idle_exp());
    endtask

    task automatic make_pkt(input logic [3:0] ver, input logic [3:0] ihl, input logic [7:0] ttl,
                            input int npay, input logic [15:0] id, input bit corrupt);
        int hw;
        int s;
        hw = (ihl < 5) ? 5 : int'(ihl);
        pw.delete();
        pw.push_back({ver, ihl, 8'h00, 16'(4 * (hw + npay))});
        pw.push_back({id, 16'h4000});
        pw.push_back({ttl, 8'd17, 16'h0000});
        pw.push_back(32'h0A000001);
        pw.push_back(32'hC0A80001);
        for (int k = 5; k < hw; k++) pw.push_back(32'h01010101 * k);
        s = 0;
        for (int k = 0; k < hw; k++) s = s + int'(pw[k][31:16]) + int'(pw[k][15:0]);
        while (s > 65535) s = (s & 65535) + (s >> 16);
        pw[2][15:0] = ~s[15:0] ^ (corrupt ? 16'h0001 : 16'h0000);
        for (int k = 0; k < npay; k++) pw.push_back(32'hD0000000 + k);
    endtask

    // expected output of the frame held in pw, then drive it with two trailers
    task automatic send_pkt(input string tag, input int gap_after);
        int n, ihl, s, c;
        bit ok, texp, fwd;
        logic [31:0] w;
        exp_t e;
        n = pw.size();
        ihl = int'(pw[0][27:24]);
        ok = 0;
        if (pw[0][31:28] == 4'd4 && ihl >= 5 && n >= ihl) begin   // R2, R9
            s = 0;
            for (int k = 0; k < ihl; k++) s = s + int'(pw[k][31:16]) + int'(pw[k][15:0]);
            while (s > 65535) s = (s & 65535) + (s >> 16);
            ok = (s == 65535);                                    // R3
        end
        texp = ok && (pw[2][31:24] <= 8'd1);                      // R7
        fwd  = ok ? !texp : !drop_mode;                           // R4, R11
        for (int i = 0; i < n + 2; i++) begin
            w = (i < n) ? pw[i] : 32'hA5A50000 + i;
            e = idle_exp();
            e.tag = tag;
            if (fwd) begin
                e.d = w;
                if (ok && i == 2) begin                           // R5, R6
                    c = int'(w[15:0]) + 256;
                    if (c > 65535) c = c - 65535;
                    e.d = {w[31:24] - 8'd1, w[23:16], c[15:0]};
                end
                e.den = 1;
                e.sof = (i == 0);
                e.eof = (i == n - 1);
                e.sop = ok && (i == ihl) && (i < n);              // R8
            end
            e.err  = (i == 0) && !ok;
            e.icmp = (i == 0) && texp;
            step(w, 1, i == 0, i == n - 1, e);
            if (i == gap_after) idle(2);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // reset state (R1)
        n_cmp++;
        if ({out_den, out_sof, out_eof, out_sop, out_hdr_err, icmp_req} !== 6'b0 || out_data !== '0)
            fail("R1 reset", "reset", out_data, '0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LAT; i++) exp_q.push_back(idle_exp());

        drop_mode = 1'b1;
        make_pkt(4, 5, 64, 3, 16'h1234, 0);  send_pkt("R5 R6 R8 basic ihl5", -1);
        idle(3);
        make_pkt(4, 7, 30, 2, 16'h0101, 0);  send_pkt("R8 options ihl7", -1);
        make_pkt(4, 15, 9, 1, 16'h0202, 0);  send_pkt("R8 ihl15", -1);
        idle(2);
        make_pkt(4, 6, 20, 0, 16'h0303, 0);  send_pkt("R8 no payload", -1);
        make_pkt(4, 5, 2, 2, 16'h0404, 0);   send_pkt("R5 ttl2 forwarded", -1);
        make_pkt(4, 5, 1, 2, 16'h0505, 0);   send_pkt("R7 ttl1 dropped", -1);
        make_pkt(4, 5, 0, 1, 16'h0606, 0);   send_pkt("R7 ttl0 dropped", -1);
        make_pkt(6, 5, 64, 2, 16'h0707, 0);  send_pkt("R2 R4 version6 drop", -1);
        make_pkt(4, 5, 64, 2, 16'h0808, 1);  send_pkt("R3 R4 bad checksum drop", -1);
        make_pkt(4, 4, 64, 2, 16'h0909, 0);  send_pkt("R2 ihl4 drop", -1);
        make_pkt(4, 6, 64, 0, 16'h0A0A, 0);
        while (pw.size() > 4) void'(pw.pop_back());
        send_pkt("R9 truncated drop", -1);
        for (int id = 0; id < 65536; id++) begin
            make_pkt(4, 5, 77, 2, id[15:0], 0);
            if (pw[2][15:8] == 8'hFF) break;
        end
        send_pkt("R6 end-around carry", -1);
        make_pkt(4, 5, 50, 4, 16'h0B0B, 0);  send_pkt("R1 payload gap", 6);

        // back-to-back short frames fill the verdict queue (R10)
        for (int r = 0; r < 6; r++) begin
            make_pkt(4, 5, 40, 0, 16'h0C00 + r, 0);
            if (r % 2 == 0) while (pw.size() > 1) void'(pw.pop_back());
            send_pkt("R10 back-to-back", -1);
        end
        make_pkt(4, 5, 33, 1, 16'h0D0D, 0);  send_pkt("R10 after burst", -1);

        // flag mode: malformed frames pass unchanged (R4, R11)
        idle(20);
        drop_mode = 1'b0;
        make_pkt(5, 5, 64, 2, 16'h0E0E, 0);  send_pkt("R2 R4 version5 flag", -1);
        make_pkt(4, 6, 64, 1, 16'h0F0F, 1);  send_pkt("R3 R4 bad checksum flag", -1);
        make_pkt(4, 5, 1, 1, 16'h1010, 0);   send_pkt("R7 ttl1 flag mode", -1);
        make_pkt(4, 5, 64, 0, 16'h1111, 0);
        while (pw.size() > 2) void'(pw.pop_back());
        send_pkt("R9 truncated flag", -1);
        make_pkt(4, 8, 128, 2, 16'h1212, 0); send_pkt("R5 R8 valid flag mode", -1);
        idle(LAT + 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule